// File: doc/BRIEF.md
# Control-Flow Trace Message Encoder

This block sits beside a processor core and turns the stream of retired instructions into a compact byte stream for a trace store. Most instructions produce no output. The block only counts them in a 4-bit register. A control-flow change emits one message byte: a taken direct branch, a taken indirect branch, or an exception. That byte carries the kind of change and the number of instructions retired since the previous message. A long run with no control-flow change emits a filler rollover byte once every sixteen instructions.

A taken indirect branch also needs its target address, so it produces a five-byte entry. The four address bytes come out first, most significant byte first. The message byte comes out last, so it is always the newest byte of the entry. These five bytes go out on consecutive cycles. While they are going out, the block lowers its ready output to hold back the retire stream. A trace-enable input gates the whole block, and the core's reset is expected to drop it.

Top module: `cft_encoder`

## Requirements
- R1: After a synchronous reset, `tb_valid` is 0, `ret_ready` is 1 and the instruction count is 0. A direct branch retired first reports a count of 0, giving the byte 0x80.
- R2: A retire with `ret_exc`=1 emits one byte: bit 7 is 0, bits 6:4 equal `exc_vec`, and bits 3:0 hold the count. The count does not include the exception event itself.
- R3: A taken direct branch emits one byte. Its upper nibble is 1000, or 1100 when `ret_ckpt`=1. Its lower nibble is the count, which does not include the branch itself.
- R4: A taken indirect branch emits five bytes on five consecutive cycles, in this order: target[31:24], target[23:16], target[15:8], target[7:0], then the message byte. The message byte's upper nibble is 1001, or 1101 when checkpointed, and its lower nibble is the count. `ret_ready` is 0 during the four cycles after the retire is accepted.
- R5: A retire with `ret_cfail`=1 is counted as one instruction and emits nothing, even when a branch flag is set.
- R6: When a non-branch instruction retires while the count is already 15, the byte 0xFF is emitted and the count returns to 0.
- R7: When the instruction that retires while the count is 15 is a taken branch, the branch message is emitted with a count field of 15, and no rollover byte is emitted.
- R8: The count returns to 0 after every emitted message, so two control-flow changes in a row report a count of 0.
- R9: A retire with `ret_dbg`=1 emits nothing and leaves the count unchanged.
- R10: While `trace_en` is 0, no byte is emitted, retires are accepted and ignored, the count is held at 0, and an indirect entry that is partly sent is dropped.
- R11: The first byte caused by an accepted retire appears on `tb_byte`/`tb_valid` in the cycle that follows the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Trace enable; 0 gates all output |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_ready | output | 1 | Encoder can accept a retire |
| ret_direct | input | 1 | Instruction is a direct branch |
| ret_indirect | input | 1 | Instruction is an indirect branch |
| ret_ckpt | input | 1 | Branch is checkpointed |
| ret_exc | input | 1 | Event is an exception entry |
| ret_dbg | input | 1 | Event is a debug exception (not traced) |
| ret_cfail | input | 1 | Instruction failed its condition |
| exc_vec | input | 3 | Bits 4:2 of the exception vector offset |
| br_target | input | 32 | Indirect branch target address |
| tb_valid | output | 1 | Trace byte valid |
| tb_byte | output | 8 | Trace byte toward the store |

## Verification
The assertions assume that a retire stays valid with its fields held steady until the cycle `ret_ready` accepts it. They also assume that at most one class flag among direct, indirect, exception and debug is set on a given retire, and that `trace_en` changes only between clock edges. The stimulus drives each retire on the falling edge and holds it until it sees `ret_ready`. It sets only one class flag per retire. It toggles `trace_en` only on falling edges, including once while an indirect entry is partway out.

// File: rtl/cft_pkg.sv
package cft_pkg;
    parameter int TGT_W = 32;
    localparam int CNT_W = 4;
    localparam int TGT_BYTES = TGT_W / 8;
    localparam int REM_W = $clog2(TGT_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    localparam logic [3:0] TY_DIR    = 4'b1000;
    localparam logic [3:0] TY_DIR_CK = 4'b1100;
    localparam logic [3:0] TY_IND    = 4'b1001;
    localparam logic [3:0] TY_IND_CK = 4'b1101;
    localparam logic [7:0] ROLL_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_COUNT,
        EV_ROLL,
        EV_BRANCH,
        EV_INDIRECT,
        EV_EXC
    } ev_e;

    typedef struct packed {
        logic direct;
        logic indirect;
        logic ckpt;
        logic exc;
        logic dbg;
        logic cfail;
    } cls_t;

    typedef struct packed {
        ev_e              kind;
        logic [7:0]       msg;
        logic [TGT_W-1:0] target;
    } entry_t;

    function automatic logic [7:0] exc_msg(logic [2:0] vec, logic [CNT_W-1:0] cnt);
        return {1'b0, vec, cnt};
    endfunction

    function automatic logic [7:0] flow_msg(logic [3:0] ty, logic [CNT_W-1:0] cnt);
        return {ty, cnt};
    endfunction

    function automatic logic emits(ev_e k);
        return (k == EV_ROLL) || (k == EV_BRANCH) || (k == EV_INDIRECT) || (k == EV_EXC);
    endfunction
endpackage

// File: rtl/cft_classify.sv
module cft_classify
    import cft_pkg::*;
(
    input  logic             valid,
    input  cls_t             cls,
    input  logic [2:0]       vec,
    input  logic [TGT_W-1:0] target,
    input  logic [CNT_W-1:0] cnt,
    output entry_t           ent
);
    logic taken;
    assign taken = !cls.cfail && (cls.direct || cls.indirect);

    always_comb begin
        ent = '0;
        ent.kind = EV_NONE;
        if (valid && !cls.dbg) begin
            if (cls.exc) begin
                ent.kind = EV_EXC;
                ent.msg  = exc_msg(vec, cnt);
            end else if (!taken) begin
                if (cnt == CNT_MAX) begin
                    ent.kind = EV_ROLL;
                    ent.msg  = ROLL_BYTE;
                end else begin
                    ent.kind = EV_COUNT;
                end
            end else if (cls.indirect) begin
                ent.kind   = EV_INDIRECT;
                ent.msg    = flow_msg(cls.ckpt ? TY_IND_CK : TY_IND, cnt);
                ent.target = target;
            end else begin
                ent.kind = EV_BRANCH;
                ent.msg  = flow_msg(cls.ckpt ? TY_DIR_CK : TY_DIR, cnt);
            end
        end
    end
endmodule

// File: rtl/cft_count.sv
module cft_count
    import cft_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  ev_e              kind,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (emits(kind)) begin
            cnt <= '0;
        end else if (kind == EV_COUNT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: every emitted message leaves the count at zero
    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (en && emits(kind)) |=> (cnt == '0));

    // R10: disabled trace holds the count at zero
    p_cnt_off_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));
endmodule

// File: rtl/cft_serializer.sv
module cft_serializer
    import cft_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  entry_t     ent,
    output logic       busy,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    logic [REM_W-1:0] rem;
    logic [TGT_W-1:0] shreg;
    logic [7:0]       held;

    assign busy = (rem != '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            rem       <= '0;
            shreg     <= '0;
            held      <= '0;
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else if (busy) begin
            out_valid <= 1'b1;
            rem       <= rem - 1'b1;
            if (rem > REM_W'(1)) begin
                out_byte <= shreg[TGT_W-1 -: 8];
                shreg    <= shreg << 8;
            end else begin
                out_byte <= held;
            end
        end else begin
            case (ent.kind)
                EV_INDIRECT: begin
                    out_valid <= 1'b1;
                    out_byte  <= ent.target[TGT_W-1 -: 8];
                    shreg     <= ent.target << 8;
                    held      <= ent.msg;
                    rem       <= REM_W'(TGT_BYTES);
                end
                EV_ROLL, EV_BRANCH, EV_EXC: begin
                    out_valid <= 1'b1;
                    out_byte  <= ent.msg;
                end
                default: out_valid <= 1'b0;
            endcase
        end
    end

    // R4: entry bytes leave on consecutive cycles
    p_consec_r4: assert property (@(posedge clk) disable iff (rst)
        (en && busy) |=> out_valid);

    // R4: the last byte of a five-byte entry is an indirect message
    p_entry_tail_r4: assert property (@(posedge clk) disable iff (rst)
        (en && rem == REM_W'(1)) |=>
            (out_valid && (out_byte[7:4] == TY_IND || out_byte[7:4] == TY_IND_CK)));
endmodule

// File: rtl/cft_encoder.sv
module cft_encoder
    import cft_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trace_en,
    input  logic             ret_valid,
    output logic             ret_ready,
    input  logic             ret_direct,
    input  logic             ret_indirect,
    input  logic             ret_ckpt,
    input  logic             ret_exc,
    input  logic             ret_dbg,
    input  logic             ret_cfail,
    input  logic [2:0]       exc_vec,
    input  logic [TGT_W-1:0] br_target,
    output logic             tb_valid,
    output logic [7:0]       tb_byte
);
    logic             busy;
    logic             accept;
    logic [CNT_W-1:0] cnt;
    cls_t             cls;
    entry_t           ent;

    assign ret_ready = !busy || !trace_en;
    assign accept    = ret_valid && trace_en && !busy;

    always_comb begin
        cls.direct   = ret_direct;
        cls.indirect = ret_indirect;
        cls.ckpt     = ret_ckpt;
        cls.exc      = ret_exc;
        cls.dbg      = ret_dbg;
        cls.cfail    = ret_cfail;
    end

    cft_classify u_classify (
        .valid  (accept),
        .cls    (cls),
        .vec    (exc_vec),
        .target (br_target),
        .cnt    (cnt),
        .ent    (ent)
    );

    cft_count u_count (
        .clk  (clk),
        .rst  (rst),
        .en   (trace_en),
        .kind (ent.kind),
        .cnt  (cnt)
    );

    cft_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .en        (trace_en),
        .ent       (ent),
        .busy      (busy),
        .out_valid (tb_valid),
        .out_byte  (tb_byte)
    );

    // R10: no output the cycle after trace is disabled
    p_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !trace_en |=> !tb_valid);

    // R9: an accepted debug event produces no byte
    p_dbg_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_ready && trace_en && ret_dbg) |=> !tb_valid);

    // R4: the retire path stalls only while tracing
    p_stall_r4: assert property (@(posedge clk) disable iff (rst)
        !ret_ready |-> trace_en);
endmodule

// File: tb/tb_cft_encoder.sv
module tb_cft_encoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trace_en = 1'b0;
    logic        ret_valid = 1'b0;
    logic        ret_ready;
    logic        ret_direct = 1'b0;
    logic        ret_indirect = 1'b0;
    logic        ret_ckpt = 1'b0;
    logic        ret_exc = 1'b0;
    logic        ret_dbg = 1'b0;
    logic        ret_cfail = 1'b0;
    logic [2:0]  exc_vec = '0;
    logic [31:0] br_target = '0;
    logic        tb_valid;
    logic [7:0]  tb_byte;

    always #4 clk = ~clk;

    cft_encoder dut (
        .clk(clk), .rst(rst), .trace_en(trace_en),
        .ret_valid(ret_valid), .ret_ready(ret_ready),
        .ret_direct(ret_direct), .ret_indirect(ret_indirect),
        .ret_ckpt(ret_ckpt), .ret_exc(ret_exc), .ret_dbg(ret_dbg),
        .ret_cfail(ret_cfail), .exc_vec(exc_vec), .br_target(br_target),
        .tb_valid(tb_valid), .tb_byte(tb_byte)
    );

    int    errors = 0;
    int    checks = 0;
    string phase = "R1";
    bit    done = 1'b0;

    logic [7:0] q[$];
    int         mcnt = 0;
    bit         exp_valid = 1'b0;
    logic [7:0] exp_byte = '0;

    // behavioural reference model, updated at each rising edge
    always @(posedge clk) begin
        if (rst || !trace_en) begin
            q.delete();
            mcnt = 0;
            exp_valid = 1'b0;
        end else if (q.size() > 0) begin
            exp_byte = q.pop_front();
            exp_valid = 1'b1;
        end else begin
            exp_valid = 1'b0;
            if (ret_valid) begin
                if (ret_dbg) begin
                end else if (ret_exc) begin
                    q.push_back({1'b0, exc_vec, 4'(mcnt)});
                    mcnt = 0;
                end else if (!ret_cfail && ret_indirect) begin
                    q.push_back(br_target[31:24]);
                    q.push_back(br_target[23:16]);
                    q.push_back(br_target[15:8]);
                    q.push_back(br_target[7:0]);
                    q.push_back({ret_ckpt ? 4'hD : 4'h9, 4'(mcnt)});
                    mcnt = 0;
                end else if (!ret_cfail && ret_direct) begin
                    q.push_back({ret_ckpt ? 4'hC : 4'h8, 4'(mcnt)});
                    mcnt = 0;
                end else if (mcnt == 15) begin
                    q.push_back(8'hFF);
                    mcnt = 0;
                end else begin
                    mcnt = mcnt + 1;
                end
            end
            if (q.size() > 0) begin
                exp_byte = q.pop_front();
                exp_valid = 1'b1;
            end
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        #1;
        if (!done) begin
            checks++;
            if (tb_valid !== exp_valid) begin
                errors++;
                $display("FAIL %s R11 valid: actual=%0b expected=%0b", phase, tb_valid, exp_valid);
            end
            if (exp_valid) begin
                checks++;
                if (tb_byte !== exp_byte) begin
                    errors++;
                    $display("FAIL %s byte: actual=%02h expected=%02h", phase, tb_byte, exp_byte);
                end
            end
            checks++;
            if (ret_ready !== ((q.size() == 0) || !trace_en || rst)) begin
                errors++;
                $display("FAIL %s R4 ready: actual=%0b expected=%0b", phase, ret_ready,
                         (q.size() == 0) || !trace_en);
            end
        end
    end

    task automatic retire(input bit d, input bit i, input bit ck, input bit e,
                          input bit g, input bit cf, input logic [2:0] v,
                          input logic [31:0] t);
        @(negedge clk);
        ret_direct = d; ret_indirect = i; ret_ckpt = ck; ret_exc = e;
        ret_dbg = g; ret_cfail = cf; exc_vec = v; br_target = t;
        ret_valid = 1'b1;
        #1;
        while (!ret_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        ret_valid = 1'b0;
    endtask

    task automatic plain(input int n);
        for (int k = 0; k < n; k++) retire(0, 0, 0, 0, 0, 0, 3'd0, 32'd0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        trace_en = 1'b1;
        idle(2);

        phase = "R1";            // first branch after reset counts zero
        retire(1, 0, 0, 0, 0, 0, 3'd0, 32'd0);
        idle(2);

        phase = "R3";            // direct and checkpointed direct
        plain(3);
        retire(1, 0, 0, 0, 0, 0, 3'd0, 32'd0);
        retire(1, 0, 1, 0, 0, 0, 3'd0, 32'd0);
        idle(2);

        phase = "R8";            // back-to-back changes
        retire(1, 0, 0, 0, 0, 0, 3'd0, 32'd0);
        retire(0, 0, 0, 1, 0, 0, 3'd5, 32'd0);
        idle(2);

        phase = "R5";            // condition-failed instructions count
        plain(1);
        retire(0, 0, 0, 0, 0, 1, 3'd0, 32'd0);
        retire(1, 0, 0, 0, 0, 1, 3'd0, 32'd0);
        retire(0, 1, 0, 0, 0, 1, 3'd0, 32'h1234_5678);
        retire(1, 0, 1, 0, 0, 0, 3'd0, 32'd0);
        idle(2);

        phase = "R2";            // exception bytes
        retire(0, 0, 0, 1, 0, 0, 3'd6, 32'd0);
        plain(5);
        retire(0, 0, 0, 1, 0, 0, 3'd7, 32'd0);
        idle(2);

        phase = "R4";            // indirect five-byte entries
        plain(2);
        retire(0, 1, 0, 0, 0, 0, 3'd0, 32'hDEAD_BEEF);
        retire(0, 1, 1, 0, 0, 0, 3'd0, 32'h0000_0100);
        plain(1);
        idle(3);

        phase = "R6";            // rollover after 16 straight-line
        plain(16);
        plain(31);
        idle(2);

        phase = "R7";            // 16th is a branch
        plain(15);
        retire(1, 0, 0, 0, 0, 0, 3'd0, 32'd0);
        plain(15);
        retire(0, 1, 0, 0, 0, 0, 3'd0, 32'hA5A5_0F0F);
        idle(6);

        phase = "R9";            // debug events ignored
        plain(2);
        retire(0, 0, 0, 0, 1, 0, 3'd0, 32'd0);
        plain(1);
        retire(1, 0, 0, 0, 0, 0, 3'd0, 32'd0);
        idle(2);

        phase = "R10";           // trace disabled
        plain(3);
        @(negedge clk); trace_en = 1'b0;
        plain(2);
        retire(1, 0, 0, 0, 0, 0, 3'd0, 32'd0);
        @(negedge clk); trace_en = 1'b1;
        retire(1, 0, 0, 0, 0, 0, 3'd0, 32'd0);
        retire(0, 1, 0, 0, 0, 0, 3'd0, 32'hCAFE_F00D);
        idle(1);
        trace_en = 1'b0;
        idle(3);
        trace_en = 1'b1;
        retire(1, 0, 1, 0, 0, 0, 3'd0, 32'd0);
        idle(2);

        phase = "R1";            // reset mid-run clears the count
        plain(4);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        retire(1, 0, 0, 0, 0, 0, 3'd0, 32'd0);
        idle(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule